// File: doc/BRIEF.md
# Post-Lock Recovery Reset Generator

This block sits beside an audio receiver whose internal state can go bad when an input stream first appears or is interrupted. It watches the receiver's error status line, which is high while the receiver is unlocked or in error and low while it is locked. When the line settles low, the block applies one active-low reset pulse to the receiver. The pulse lasts at least the cycle equivalent of 200 µs, and this clears the latent fault.

During and after the pulse, the receiver reports an error until its PLL locks again. That stretch is masked, so the pulse cannot retrigger itself. Mute is held high while the pulse is applied and while relock is awaited. Once lock returns, the block raises a recovered flag and drops mute. If the error line rises again after recovery, the whole sequence is rearmed for the next lock.

The status line passes through two synchronizer flops. A low level counts as lock only after it has held for a debounce count of consecutive synchronized cycles.

Top module: `lock_recovery_pulser`

## Requirements
- R1: After reset, dev_rst_n is 1, mute is 0 and recovered is 0. While rx_err_in stays high, they keep these values.
- R2: A pulse starts only after rx_err_in has been low for DEBOUNCE_CYCLES consecutive cycles. A low run of DEBOUNCE_CYCLES-1 cycles starts no pulse. dev_rst_n falls within DEBOUNCE_CYCLES+4 cycles of the start of a qualifying low run.
- R3: Each pulse holds dev_rst_n low for exactly max(PULSE_CYCLES, CLK_HZ/5000) consecutive cycles.
- R4: mute is 1 whenever dev_rst_n is 0. It stays 1 from the release of the pulse until recovery.
- R5: rx_err_in high during the pulse and after its release does not start another pulse. Exactly one pulse is produced per lock event.
- R6: After release, once rx_err_in has been low for DEBOUNCE_CYCLES consecutive cycles, recovered becomes 1 and mute becomes 0. This also holds when rx_err_in stayed low through the whole pulse.
- R7: While recovered is 1, a high rx_err_in clears recovered within 4 cycles. The next qualifying low run then produces a new pulse.
- R8: During the wait after release, a low run shorter than DEBOUNCE_CYCLES leaves recovered at 0 and mute at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_in | input | 1 | Receiver error status, high = unlocked or in error, asynchronous |
| dev_rst_n | output | 1 | Active-low reset to the receiver |
| mute | output | 1 | High while recovery is in progress |
| recovered | output | 1 | High after relock following a pulse |

## Verification
Two functions can coincide in one cycle: the end of the pulse and the start of the relock debounce. The case that matters is a status line that never rises during the pulse. If the mask leaked, the low level already present could complete recovery early, or the line could look like a fresh lock and fire a second pulse. The bench provokes this by holding rx_err_in low through a whole pulse. It then checks that no second pulse appears and that recovered follows only after the debounce has run again from the release.

// File: rtl/lock_recovery_pulser.sv
module lock_recovery_pulser #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int PULSE_CYCLES    = 10_000,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_err_in,
  output logic dev_rst_n,
  output logic mute,
  output logic recovered
);
  localparam int MIN_PULSE = CLK_HZ / 5000;
  localparam int EFF_PULSE = (PULSE_CYCLES < MIN_PULSE) ? MIN_PULSE : PULSE_CYCLES;
  localparam int PW = $clog2(EFF_PULSE + 1);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [PW-1:0] PLAST = PW'(EFF_PULSE - 1);
  localparam logic [DW-1:0] DMAX  = DW'(DEBOUNCE_CYCLES);

  typedef enum logic [1:0] {S_WAIT, S_PULSE, S_RELOCK, S_DONE} st_t;

  st_t state, nxt;
  logic [1:0] sync_q;
  logic [DW-1:0] deb_cnt;
  logic [PW-1:0] pcnt;
  logic err_s, lock_stable;

  assign err_s = sync_q[1];
  assign lock_stable = (deb_cnt == DMAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_err_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         deb_cnt <= '0;
    else if (state == S_PULSE || err_s) deb_cnt <= '0;
    else if (!lock_stable)              deb_cnt <= deb_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pcnt <= '0;
    else if (state == S_PULSE) pcnt <= pcnt + 1'b1;
    else                       pcnt <= '0;

  always_comb begin
    nxt = state;
    case (state)
      S_WAIT:   if (lock_stable) nxt = S_PULSE;
      S_PULSE:  if (pcnt == PLAST) nxt = S_RELOCK;
      S_RELOCK: if (lock_stable) nxt = S_DONE;
      S_DONE:   if (err_s) nxt = S_WAIT;
      default:  nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_WAIT;
      dev_rst_n <= 1'b1;
      mute      <= 1'b0;
      recovered <= 1'b0;
    end else begin
      state     <= nxt;
      dev_rst_n <= (nxt != S_PULSE);
      mute      <= (nxt == S_PULSE) || (nxt == S_RELOCK);
      recovered <= (nxt == S_DONE);
    end

  assert_trigger_on_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_rst_n) |-> $past(lock_stable));
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |-> $past(pcnt) == PLAST);
  assert_mute_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |-> mute);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rst_n) |=> dev_rst_n);
  assert_recovered_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    recovered |-> (dev_rst_n && !mute));
  assert_rearm_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recovered) |-> $past(err_s));
endmodule

// File: tb/lock_recovery_pulser_tb.sv
module lock_recovery_pulser_tb_top;
  localparam int DEB = 4;
  localparam int PULSE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_err_in = 1'b1;
  logic dev_rst_n, mute, recovered;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lock_recovery_pulser #(.CLK_HZ(200_000), .PULSE_CYCLES(10), .DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_err_in(rx_err_in),
    .dev_rst_n(dev_rst_n), .mute(mute), .recovered(recovered));

  // {err, hold[15:0], exp dev_rst_n, exp mute, exp recovered}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 16'd20, 3'b100},  // R1 idle
    {1'b0, 16'd10, 3'b010},  // R2 R4 pulse begins
    {1'b1, 16'd20, 3'b010},  // R5 error masked during pulse
    {1'b1, 16'd40, 3'b110},  // R4 R5 released, waiting relock
    {1'b0, 16'd10, 3'b101},  // R6 recovered
    {1'b1, 16'd10, 3'b100},  // R7 rearmed, no pulse
    {1'b0, 16'd10, 3'b010},  // R7 new pulse
    {1'b0, 16'd70, 3'b101}   // R6 low through pulse, single pulse
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual rst/mute/rec=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_err_in = 1'b1;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lows;
    step(1);
    chk("R1 in reset", {dev_rst_n, mute, recovered}, 3'b100);
    do_reset();
    chk("R1 after reset", {dev_rst_n, mute, recovered}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      rx_err_in = VEC[i][19];
      step(int'(VEC[i][18:3]));
      chk($sformatf("vector %0d", i), {dev_rst_n, mute, recovered}, VEC[i][2:0]);
    end

    // R2: a low run one cycle short of the debounce count must not trigger
    do_reset();
    rx_err_in = 1'b0;
    step(DEB - 1);
    rx_err_in = 1'b1;
    step(15);
    chk("R2 short low ignored", {dev_rst_n, mute, recovered}, 3'b100);

    // R2 boundary: exactly DEB low cycles triggers; R3 width measured
    rx_err_in = 1'b0;
    step(DEB);
    rx_err_in = 1'b1;
    lows = 0;
    for (int c = 0; c < DEB + 4; c++) begin
      step(1);
      if (!dev_rst_n) lows++;
    end
    chk("R2 exact debounce triggers", {2'b00, lows > 0}, 3'b001);
    for (int c = 0; c < PULSE + 20; c++) begin
      step(1);
      if (!dev_rst_n) lows++;
    end
    checks++;
    if (lows != PULSE) begin
      failures++;
      $display("FAIL R3 pulse width actual=%0d expected=%0d", lows, PULSE);
    end
    chk("R4 relock wait", {dev_rst_n, mute, recovered}, 3'b110);

    // R8: short low during relock wait does not complete recovery
    rx_err_in = 1'b0;
    step(DEB - 1);
    rx_err_in = 1'b1;
    step(10);
    chk("R8 short low in relock", {dev_rst_n, mute, recovered}, 3'b110);
    rx_err_in = 1'b0;
    step(DEB + 4);
    chk("R6 relock completes", {dev_rst_n, mute, recovered}, 3'b101);

    // R7: loss of lock clears recovered within 4 cycles
    rx_err_in = 1'b1;
    step(4);
    chk("R7 recovered cleared", {dev_rst_n, mute, recovered}, 3'b100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule